// File: doc/BRIEF.md
# Core Boundary Wrapper Chain

This block places one dedicated test cell on every input and every output terminal of an embedded core and links the cells into a single serial chain. The cells on the input side sit between the wrapper's functional inputs and the core inputs. The cells on the output side sit between the core outputs and the wrapper's functional outputs. A two-bit mode value from an external instruction decoder selects how the cells drive their functional outputs. In transparent mode they pass values straight through. In core-side test mode they drive the core inputs. In wrapper-side test mode they drive the wrapper outputs. In safe mode they force fixed values.

Each cell has a capture/shift flop and a separate update flop. Capture and shift strobes act only on the shift flops, so test data can move through the chain while the core keeps running. Only an update strobe changes what the cells drive. The numbers of input cells and output cells are separate parameters. Safe values are given as parameter vectors.

Top module: `wbr_chain`

## Requirements
- R1: With mode = 0 (transparent), `core_in` equals `wfi` and `wfo` equals `core_out` in the same cycle.
- R2: With mode = 1 (core-side test), `core_in[i]` equals the update flop of input cell i, and `wfo` still equals `core_out`.
- R3: With mode = 2 (wrapper-side test), `wfo[j]` equals the update flop of output cell j, and `core_in` still equals `wfi`.
- R4: With mode = 3 (safe), `core_in` equals parameter SAFE_IN and `wfo` equals parameter SAFE_OUT, whatever the update flops hold.
- R5: A clock edge with `capture_en` high and `shift_en` low loads every shift flop from its cell's functional input. Input cell i loads `wfi[i]`. Output cell j loads `core_out[j]`.
- R6: Chain position 0 is input cell 0. Positions N_IN-1 and N_IN are adjacent, the second being output cell 0. The last position is output cell N_OUT-1. A clock edge with `shift_en` high moves `si` into position 0 and each position into the next. `so` always shows the shift flop at the last position.
- R7: When `shift_en` and `capture_en` are both high, the edge shifts and does not capture.
- R8: Shift and capture edges never change `core_in` or `wfo`. Only an edge with `update_en` high changes the driven test values.
- R9: A clock edge with `update_en` high copies every shift flop into its update flop at once, using the values held before that edge.
- R10: A synchronous active-high `rst` clears all shift and update flops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 transparent, 1 core-side test, 2 wrapper-side test, 3 safe |
| shift_en | input | 1 | Shift strobe for the chain |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| si | input | 1 | Serial chain input |
| so | output | 1 | Serial chain output |
| wfi | input | N_IN | Wrapper functional inputs |
| core_in | output | N_IN | Drives the core inputs |
| core_out | input | N_OUT | Core outputs |
| wfo | output | N_OUT | Wrapper functional outputs |

## Verification
The hold properties assume that `mode` is a known value and stays fixed across the cycles being compared. They also assume that `wfi` and `core_out` do not move while the driven side is sampled from the update flops. The stimulus changes `mode` and the functional inputs only on falling edges, and only between strobe sequences. It holds the functional inputs steady during every shift and capture burst run in a test mode. Shift bursts in wrapper-side test mode watch `wfo` on every cycle, so any leak from the shift flops to the driven side is caught at the ports.

// File: rtl/wbr_pkg.sv
package wbr_pkg;
  typedef enum logic [1:0] {
    WBR_NORMAL  = 2'd0,
    WBR_INWARD  = 2'd1,
    WBR_OUTWARD = 2'd2,
    WBR_SAFE    = 2'd3
  } wbr_mode_e;
endpackage

// File: rtl/wbr_mode_dec.sv
module wbr_mode_dec
  import wbr_pkg::*;
(
  input  logic [1:0] mode,
  output logic       in_sel_upd,
  output logic       in_sel_safe,
  output logic       out_sel_upd,
  output logic       out_sel_safe
);
  wbr_mode_e m;
  always_comb begin
    m            = wbr_mode_e'(mode);
    in_sel_upd   = 1'b0;
    in_sel_safe  = 1'b0;
    out_sel_upd  = 1'b0;
    out_sel_safe = 1'b0;
    case (m)
      WBR_INWARD:  in_sel_upd = 1'b1;
      WBR_OUTWARD: out_sel_upd = 1'b1;
      WBR_SAFE: begin
        in_sel_safe  = 1'b1;
        out_sel_safe = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wbr_cell.sv
module wbr_cell #(
  parameter logic SAFE_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cfi,
  input  logic ti,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic sel_upd,
  input  logic sel_safe,
  output logic cfo,
  output logic to
);
  logic sh_q;
  logic up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= 1'b0;
      up_q <= 1'b0;
    end else begin
      if (shift_en)        sh_q <= ti;
      else if (capture_en) sh_q <= cfi;
      if (update_en)       up_q <= sh_q;
    end
  end

  always_comb begin
    if (sel_safe)     cfo = SAFE_BIT;
    else if (sel_upd) cfo = up_q;
    else              cfo = cfi;
  end

  assign to = sh_q;
endmodule

// File: rtl/wbr_chain.sv
module wbr_chain #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter logic [N_IN-1:0]  SAFE_IN  = '0,
  parameter logic [N_OUT-1:0] SAFE_OUT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic             si,
  output logic             so,
  input  logic [N_IN-1:0]  wfi,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] wfo
);
  localparam int LEN = N_IN + N_OUT;

  logic [LEN:0] link;
  logic in_sel_upd, in_sel_safe, out_sel_upd, out_sel_safe;

  assign link[0] = si;
  assign so      = link[LEN];

  wbr_mode_dec u_dec (
    .mode         (mode),
    .in_sel_upd   (in_sel_upd),
    .in_sel_safe  (in_sel_safe),
    .out_sel_upd  (out_sel_upd),
    .out_sel_safe (out_sel_safe)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    wbr_cell #(.SAFE_BIT(SAFE_IN[i])) u_cell (
      .clk        (clk),
      .rst        (rst),
      .cfi        (wfi[i]),
      .ti         (link[i]),
      .shift_en   (shift_en),
      .capture_en (capture_en),
      .update_en  (update_en),
      .sel_upd    (in_sel_upd),
      .sel_safe   (in_sel_safe),
      .cfo        (core_in[i]),
      .to         (link[i+1])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    wbr_cell #(.SAFE_BIT(SAFE_OUT[j])) u_cell (
      .clk        (clk),
      .rst        (rst),
      .cfi        (core_out[j]),
      .ti         (link[N_IN+j]),
      .shift_en   (shift_en),
      .capture_en (capture_en),
      .update_en  (update_en),
      .sel_upd    (out_sel_upd),
      .sel_safe   (out_sel_safe),
      .cfo        (wfo[j]),
      .to         (link[N_IN+j+1])
    );
  end
endmodule

// File: rtl/wbr_chain_chk.sv
module wbr_chain_chk #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 8,
  parameter logic [N_IN-1:0]  SAFE_IN  = '0,
  parameter logic [N_OUT-1:0] SAFE_OUT = '0
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             update_en,
  input logic [N_IN-1:0]  wfi,
  input logic [N_IN-1:0]  core_in,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] wfo
);
  assert_normal_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (core_in == wfi && wfo == core_out));

  assert_inward_outside_R2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |-> (wfo == core_out));

  assert_outward_inside_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2) |-> (core_in == wfi));

  assert_safe_values_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd3) |-> (core_in == SAFE_IN && wfo == SAFE_OUT));

  // R8: without an update strobe the driven test values hold
  assert_inward_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && !update_en) |=> (mode != 2'd1 || $stable(core_in)));

  assert_outward_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && !update_en) |=> (mode != 2'd2 || $stable(wfo)));
endmodule

bind wbr_chain wbr_chain_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .SAFE_IN(SAFE_IN), .SAFE_OUT(SAFE_OUT)
) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .update_en(update_en),
  .wfi(wfi), .core_in(core_in), .core_out(core_out), .wfo(wfo)
);

// File: tb/sim_wbr_chain.sv
module sim_wbr_chain;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + NO;
  localparam logic [NI-1:0] S_IN  = 4'b1010;
  localparam logic [NO-1:0] S_OUT = 4'b0110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, si = 1'b0;
  logic so;
  logic [NI-1:0] wfi = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] wfo;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbr_chain #(.N_IN(NI), .N_OUT(NO), .SAFE_IN(S_IN), .SAFE_OUT(S_OUT)) u0 (
    .clk(clk), .rst(rst), .mode(mode), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .si(si), .so(so),
    .wfi(wfi), .core_in(core_in), .core_out(core_out), .wfo(wfo)
  );

  // mode, wfi, core_out, expected core_in, expected wfo (update flops hold in=5, out=C)
  localparam logic [17:0] VEC [0:7] = '{
    {2'd0, 4'h3, 4'h9, 4'h3, 4'h9},
    {2'd0, 4'hE, 4'h1, 4'hE, 4'h1},
    {2'd1, 4'h3, 4'h9, 4'h5, 4'h9},
    {2'd1, 4'h0, 4'hF, 4'h5, 4'hF},
    {2'd2, 4'h3, 4'h9, 4'h3, 4'hC},
    {2'd2, 4'hA, 4'h2, 4'hA, 4'hC},
    {2'd3, 4'h3, 4'h9, 4'hA, 4'h6},
    {2'd3, 4'hF, 4'hF, 4'hA, 4'h6}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // shift din in (bit L-1 first); expect so to read exp (bit L-1 first)
  task automatic shift_io(input logic [7:0] din, input logic [7:0] exp,
                          input string req, input logic [3:0] hold_wfo);
    for (int k = L-1; k >= 0; k--) begin
      @(negedge clk);
      si = din[k];
      shift_en = 1'b1;
      #1;
      check(req, {7'd0, so}, {7'd0, exp[k]});
      if (mode == 2'd2) check("R8 wfo during shift", {4'd0, wfo}, {4'd0, hold_wfo});
    end
    @(negedge clk);
    shift_en = 1'b0;
    si = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk); update_en = 1'b1;
    @(negedge clk); update_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10: reset state
    mode = 2'd1; #1 check("R10 core_in", {4'd0, core_in}, 8'h00);
    mode = 2'd2; #1 check("R10 wfo", {4'd0, wfo}, 8'h00);
    check("R10 so", {7'd0, so}, 8'h00);

    // R6 load pattern C5 while wfo held at zero (R8)
    shift_io(8'hC5, 8'h00, "R6 shift after reset", 4'h0);
    check("R8 wfo before update", {4'd0, wfo}, 8'h00);
    pulse_update();
    #1 check("R9 wfo after update", {4'd0, wfo}, 8'h0C);

    // R1..R4 table
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      mode = VEC[v][17:16]; wfi = VEC[v][15:12]; core_out = VEC[v][11:8];
      #1;
      check($sformatf("R1-4 vec%0d core_in (mode %0d)", v, mode), {4'd0, core_in}, {4'd0, VEC[v][7:4]});
      check($sformatf("R1-4 vec%0d wfo (mode %0d)", v, mode), {4'd0, wfo}, {4'd0, VEC[v][3:0]});
    end

    // R5 capture, then R6 readout in wrapper-side mode with R8 hold
    @(negedge clk); mode = 2'd0; wfi = 4'h9; core_out = 4'h6; capture_en = 1'b1;
    @(negedge clk); capture_en = 1'b0; mode = 2'd2;
    shift_io(8'h3A, 8'h69, "R5 captured data", 4'hC);
    shift_io(8'h00, 8'h3A, "R6 serial order", 4'hC);

    // R7 shift wins over capture
    @(negedge clk); wfi = 4'hF; core_out = 4'hF; si = 1'b1; shift_en = 1'b1; capture_en = 1'b1;
    @(negedge clk); shift_en = 1'b0; capture_en = 1'b0; si = 1'b0;
    shift_io(8'h00, 8'h01, "R7 shift priority", 4'hC);

    // R9 update copies all cells; R8 core_in holds until then
    @(negedge clk); mode = 2'd1; wfi = 4'h0;
    shift_io(8'hA3, 8'h00, "R6 load A3", 4'hC);
    #1 check("R8 core_in before update", {4'd0, core_in}, 8'h05);
    @(negedge clk); capture_en = 1'b1;
    @(negedge clk); capture_en = 1'b0;
    #1 check("R8 core_in after capture", {4'd0, core_in}, 8'h05);
    // chain now holds captured {F, 0} = F0
    pulse_update();
    #1 check("R9 core_in after update", {4'd0, core_in}, 8'h00);
    mode = 2'd2; #1 check("R9 wfo after update", {4'd0, wfo}, 8'h0F);

    // R4 safe has priority over update data
    mode = 2'd3; #1 check("R4 safe over update", {core_in, wfo}, {S_IN, S_OUT});

    // R10 reset mid-run clears update flops
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; mode = 2'd2;
    #1 check("R10 wfo after reset", {4'd0, wfo}, 8'h00);
    check("R10 so after reset", {7'd0, so}, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule